// File: doc/BRIEF.md
# Power Management Control/Status Unit

This block keeps the power management control and status word for a configuration-only target function and relays its events to the local side. The word holds a two-bit power state, a wake-event enable and a wake-event status bit, a four-bit data select field and a two-bit data scale field. A host write that moves the power state between full power (00) and the deep low-power state (11) raises a one-cycle, active-low interrupt towards the local side. A return from the deep low-power state to full power starts a soft reset of the local side and asks the EEPROM loader to reload the hidden registers.

The local side can request a wake event through a level input. Its rising edge sets the wake status bit. The active-low wake output follows the status bit whenever wake events are enabled. While the function sits in the deep low-power state, memory and I/O accesses and the function interrupt are blocked. The block also serves power figures: two hidden words, loaded only through the EEPROM port, supply a data byte and a scale value for each supported data select value.

Top module: `pm_csr_unit`

## Requirements
- R1: After reset the status word reads 0 (power state 00, enable 0, select 0, scale 0, status 0). The interrupt and wake outputs are high, the local reset output is high, the reload request is low and memory/I/O access is allowed.
- R2: A host write (cfg_wr_data[1:0]) that moves the power state between 00 and 11 drives lpm_int_n low for exactly the one cycle after the write edge. A write that keeps the same state gives no pulse.
- R3: A host write carrying power state 01 or 10 leaves the stored state unchanged and gives no pulse. The other fields of that write still take effect.
- R4: A change from state 11 to 00 holds local_rst_n low for RST_CYCLES cycles starting at the write edge. ee_reload_req is high for the first of those cycles, both hidden words clear to 0, and EEPROM writes to the hidden words are ignored while local_rst_n is low.
- R5: In state 11, mem_io_allow is 0 and func_irq_out is 0. In state 00, mem_io_allow is 1 and func_irq_out follows func_irq_in.
- R6: A rising edge of wake_set_in sets the status bit (bit 15) two clock edges after the input rises. An input held high sets the bit only once.
- R7: wake_n is low exactly when the status bit and the enable bit (bit 8) are both 1.
- R8: Writing 1 to bit 15 from the host clears the status bit, and writing 0 leaves it unchanged. If a rising edge of the wake input and a clear land on the same edge, the bit ends up set.
- R9: The enable bit is written by the host through bit 8 of the write data, and by the EEPROM port through ee_addr=2 with the value taken from ee_wr_data[8]. Writing 0 either way releases wake_n.
- R10: pwr_data returns the hidden data word's byte 0, 1, 2 or 3 for select values 0, 3, 4 and 7 respectively. Every other select value returns 0. The data word is loaded with ee_addr=0.
- R11: The scale field (bits [14:13]) reads the hidden scale word's bits [1:0], [3:2], [5:4] or [7:6] for select values 0, 3, 4 and 7 respectively. Every other select value, including 8 to 15, reads 0. The scale word is loaded with ee_addr=1.
- R12: The hidden words change only through the EEPROM port or the soft reset. Host writes to bits [14:13] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Host write strobe for the status word |
| cfg_wr_data | input | 16 | Host write data in status word layout |
| ee_wr_en | input | 1 | EEPROM loader write strobe |
| ee_addr | input | 2 | EEPROM target: 0 data word, 1 scale word, 2 enable bit |
| ee_wr_data | input | 32 | EEPROM loader write data |
| wake_set_in | input | 1 | Local wake request level |
| func_irq_in | input | 1 | Function interrupt from the local side |
| csr_rd | output | 16 | Current status word |
| pwr_data | output | 8 | Power data byte for the current select value |
| lpm_int_n | output | 1 | Active-low one-cycle power state change interrupt |
| wake_n | output | 1 | Active-low wake event output |
| local_rst_n | output | 1 | Active-low local soft reset |
| ee_reload_req | output | 1 | One-cycle request to reload the EEPROM contents |
| mem_io_allow | output | 1 | High when memory and I/O accesses are accepted |
| func_irq_out | output | 1 | Gated function interrupt |

## Verification
The assertions assume that rst_n is released away from a clock edge and that wake_set_in is already synchronous to the local clock, because its edge detector has no metastability stage. They also assume that the EEPROM loader writes nothing while the soft reset is running. The stimulus drives every input at the falling edge, keeps the wake input steady for whole cycles, and sends its only EEPROM write inside the reset window to check that such a write is dropped. It does not lean on that write for any other result.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;

  localparam int CSR_W    = 16;
  localparam int WORD_W   = 32;
  localparam int LANE_W   = 8;
  localparam int SCALE_W  = 2;
  localparam int LANES    = WORD_W / LANE_W;
  localparam int SCALEBITS = LANES * SCALE_W;

  localparam int BIT_STS   = 15;
  localparam int BIT_EN    = 8;
  localparam int SEL_LO    = 9;
  localparam int SCALE_LO  = 13;

  typedef enum logic [1:0] {
    PS_FULL  = 2'b00,
    PS_LITE  = 2'b01,
    PS_DEEP1 = 2'b10,
    PS_DEEP  = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    EE_DATA  = 2'd0,
    EE_SCALE = 2'd1,
    EE_CTRL  = 2'd2,
    EE_NONE  = 2'd3
  } ee_tgt_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] lane;
  } lane_t;

  function automatic lane_t lane_of(input logic [3:0] sel);
    lane_t r;
    r = '0;
    case (sel)
      4'd0: r = '{hit: 1'b1, lane: 2'd0};
      4'd3: r = '{hit: 1'b1, lane: 2'd1};
      4'd4: r = '{hit: 1'b1, lane: 2'd2};
      4'd7: r = '{hit: 1'b1, lane: 2'd3};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input lane_t l);
    return l.hit ? w[l.lane*LANE_W +: LANE_W] : '0;
  endfunction

  function automatic logic [SCALE_W-1:0] pick_scale(input logic [SCALEBITS-1:0] w,
                                                    input lane_t l);
    return l.hit ? w[l.lane*SCALE_W +: SCALE_W] : '0;
  endfunction

  function automatic logic state_legal(input logic [1:0] s);
    return (s == PS_FULL) || (s == PS_DEEP);
  endfunction

endpackage

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_csr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_state,
  output pstate_e    state,
  output logic       state_chg,
  output logic       int_pulse,
  output logic       soft_start,
  output logic       soft_active,
  output logic       reload_req
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rst_cnt;
  logic             accept;

  assign accept     = wr_en && state_legal(wr_state);
  assign state_chg  = accept && (wr_state != state);
  assign soft_start = state_chg && (state == PS_DEEP) && (wr_state == PS_FULL);
  assign soft_active = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_FULL;
      int_pulse  <= 1'b0;
      reload_req <= 1'b0;
      rst_cnt    <= '0;
    end else begin
      if (accept) state <= pstate_e'(wr_state);
      int_pulse  <= state_chg;
      reload_req <= soft_start;
      if (soft_start)       rst_cnt <= CNT_W'(RST_CYCLES);
      else if (soft_active) rst_cnt <= rst_cnt - 1'b1;
    end
  end

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |-> (state != $past(state)));  // R2
  AST_STATE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_LITE) && (state != PS_DEEP1));  // R3
  AST_RELOAD_AT_WINDOW_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_active) |-> reload_req);  // R4
  AST_RELOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !reload_req);  // R4

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake_set_in,
  input  logic host_wr,
  input  logic host_clr,
  input  logic host_en,
  input  logic ee_en_wr,
  input  logic ee_en_val,
  output logic sts,
  output logic en,
  output logic wake_rise
);

  logic samp_q, prev_q;

  assign wake_rise = samp_q && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      sts    <= 1'b0;
      en     <= 1'b0;
    end else begin
      samp_q <= wake_set_in;
      prev_q <= samp_q;
      if (wake_rise)                 sts <= 1'b1;
      else if (host_wr && host_clr)  sts <= 1'b0;
      if (host_wr)       en <= host_en;
      else if (ee_en_wr) en <= ee_en_val;
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rise |=> sts);  // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_clr && !wake_rise) |=> !sts);  // R8
  AST_STS_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> $past(wake_rise));  // R6

endmodule

// File: rtl/pm_data_mux.sv
module pm_data_mux
  import pm_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ee_wr_en,
  input  logic [1:0]           ee_addr,
  input  logic [WORD_W-1:0]    ee_wr_data,
  input  logic                 soft_start,
  input  logic                 soft_active,
  input  logic [3:0]           sel,
  output logic [LANE_W-1:0]    data_byte,
  output logic [SCALE_W-1:0]   scale
);

  logic [WORD_W-1:0]    data_q;
  logic [SCALEBITS-1:0] scale_q;
  logic                 ee_ok;
  lane_t                lane;

  assign ee_ok = ee_wr_en && !soft_start && !soft_active;
  assign lane  = lane_of(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      scale_q <= '0;
    end else if (soft_start) begin
      data_q  <= '0;
      scale_q <= '0;
    end else if (ee_ok) begin
      if (ee_addr == EE_DATA)  data_q  <= ee_wr_data;
      if (ee_addr == EE_SCALE) scale_q <= ee_wr_data[SCALEBITS-1:0];
    end
  end

  assign data_byte = pick_byte(data_q, lane);
  assign scale     = pick_scale(scale_q, lane);

  AST_HIGH_SEL_NO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    sel[3] |-> (scale == '0));  // R11
  AST_HIDDEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_wr_en && !soft_start) |=> ($stable(data_q) && $stable(scale_q)));  // R12
  AST_RESET_WINDOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_active |=> $stable(data_q));  // R4

endmodule

// File: rtl/pm_csr_unit.sv
module pm_csr_unit
  import pm_csr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  input  logic        ee_wr_en,
  input  logic [1:0]  ee_addr,
  input  logic [31:0] ee_wr_data,
  input  logic        wake_set_in,
  input  logic        func_irq_in,
  output logic [15:0] csr_rd,
  output logic [7:0]  pwr_data,
  output logic        lpm_int_n,
  output logic        wake_n,
  output logic        local_rst_n,
  output logic        ee_reload_req,
  output logic        mem_io_allow,
  output logic        func_irq_out
);

  pstate_e      state;
  logic         state_chg, int_pulse, soft_start, soft_active;
  logic         sts, en, wake_rise;
  logic [3:0]   sel_q;
  logic [1:0]   scale;
  logic         in_deep;
  logic         unused_wr_bits;

  assign unused_wr_bits = ^{cfg_wr_data[7:2], cfg_wr_data[14:13]};

  pm_state_ctrl #(.RST_CYCLES(RST_CYCLES)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_state   (cfg_wr_data[1:0]),
    .state      (state),
    .state_chg  (state_chg),
    .int_pulse  (int_pulse),
    .soft_start (soft_start),
    .soft_active(soft_active),
    .reload_req (ee_reload_req)
  );

  pm_wake_ctrl u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_set_in(wake_set_in),
    .host_wr    (cfg_wr_en),
    .host_clr   (cfg_wr_data[BIT_STS]),
    .host_en    (cfg_wr_data[BIT_EN]),
    .ee_en_wr   (ee_wr_en && (ee_addr == EE_CTRL)),
    .ee_en_val  (ee_wr_data[BIT_EN]),
    .sts        (sts),
    .en         (en),
    .wake_rise  (wake_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (cfg_wr_en) sel_q <= cfg_wr_data[SEL_LO +: 4];
  end

  pm_data_mux u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_wr_en   (ee_wr_en),
    .ee_addr    (ee_addr),
    .ee_wr_data (ee_wr_data),
    .soft_start (soft_start),
    .soft_active(soft_active),
    .sel        (sel_q),
    .data_byte  (pwr_data),
    .scale      (scale)
  );

  assign in_deep      = (state == PS_DEEP);
  assign csr_rd       = {sts, scale, sel_q, en, 6'b0, state};
  assign lpm_int_n    = !int_pulse;
  assign wake_n       = !(sts && en);
  assign local_rst_n  = !soft_active;
  assign mem_io_allow = !in_deep;
  assign func_irq_out = func_irq_in && !in_deep;

  AST_DEEP_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd[1:0] == 2'b11) |-> (!mem_io_allow && !func_irq_out));  // R5
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |-> (csr_rd[BIT_EN] && csr_rd[BIT_STS]));  // R7
  AST_INT_FOLLOWS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |=> !lpm_int_n);  // R2
  AST_RESET_WITH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ee_reload_req |-> !local_rst_n);  // R4

endmodule

// File: tb/pm_csr_unit_test.sv
module pm_csr_unit_test;

  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic        ee_wr_en = 1'b0;
  logic [1:0]  ee_addr = '0;
  logic [31:0] ee_wr_data = '0;
  logic        wake_set_in = 1'b0;
  logic        func_irq_in = 1'b0;
  logic [15:0] csr_rd;
  logic [7:0]  pwr_data;
  logic        lpm_int_n, wake_n, local_rst_n, ee_reload_req, mem_io_allow, func_irq_out;

  pm_csr_unit #(.RST_CYCLES(RSTC)) uut (.*);

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  localparam logic [31:0] DWORD = 32'hA1B2C3D4;
  localparam logic [31:0] SWORD = 32'h0000001B;

  function automatic logic [7:0] exp_byte(input logic [31:0] w, input int s);
    case (s)
      0: return w[7:0];
      3: return w[15:8];
      4: return w[23:16];
      7: return w[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] exp_scale(input logic [31:0] w, input int s);
    case (s)
      0: return w[1:0];
      3: return w[3:2];
      4: return w[5:4];
      7: return w[7:6];
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] mk(input logic st15, input logic [1:0] sc,
                                     input logic [3:0] sl, input logic e, input logic [1:0] ps);
    return {st15, sc, sl, e, 6'b0, ps};
  endfunction

  task automatic expect_out(input int kind, input logic [31:0] exp, input string tag);
    q_kind.push_back(kind);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  function automatic logic [31:0] actual_of(input int kind);
    case (kind)
      0: return {16'b0, csr_rd};
      1: return {31'b0, lpm_int_n};
      2: return {31'b0, wake_n};
      3: return {31'b0, local_rst_n};
      4: return {31'b0, ee_reload_req};
      5: return {24'b0, pwr_data};
      6: return {31'b0, mem_io_allow};
      default: return {31'b0, func_irq_out};
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q_kind.size() > 0) begin
        int k;
        logic [31:0] e, a;
        string t;
        k = q_kind.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = actual_of(k);
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
        end
      end
    end
  end

  task automatic tick;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    ee_wr_en  = 1'b0;
  endtask

  task automatic drive_cfg(input logic [15:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
  endtask

  task automatic drive_ee(input logic [1:0] a, input logic [31:0] d);
    ee_wr_en = 1'b1;
    ee_addr = a;
    ee_wr_data = d;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    func_irq_in = 1'b1;
    expect_out(0, 32'h0, "R1 csr");
    expect_out(1, 1, "R1 lpm_int_n");
    expect_out(2, 1, "R1 wake_n");
    expect_out(3, 1, "R1 local_rst_n");
    expect_out(4, 0, "R1 reload");
    expect_out(6, 1, "R1 mem_io");
    expect_out(7, 1, "R5 irq pass in D0");
    tick();

    drive_ee(2'd0, DWORD); tick();
    drive_ee(2'd1, SWORD); tick();

    // select sweep; bits 14:13 written as 11 must not reach the scale field
    for (int s = 0; s < 16; s++) begin
      drive_cfg(mk(1'b0, 2'b11, 4'(s), 1'b0, 2'b00));
      expect_out(0, {16'b0, mk(1'b0, exp_scale(SWORD, s), 4'(s), 1'b0, 2'b00)}, "R11 R12 csr scale");
      expect_out(5, {24'b0, exp_byte(DWORD, s)}, "R10 pwr_data");
      expect_out(1, 1, "R2 no pulse same state");
      tick();
    end

    drive_cfg(mk(0, 0, 4'd0, 0, 2'b11));
    expect_out(1, 0, "R2 pulse on 00->11");
    expect_out(6, 0, "R5 mem_io blocked");
    expect_out(7, 0, "R5 irq blocked");
    expect_out(0, {16'b0, mk(0, exp_scale(SWORD, 0), 4'd0, 0, 2'b11)}, "R2 state 11");
    tick();
    expect_out(1, 1, "R2 pulse one cycle");
    tick();

    drive_cfg(mk(0, 0, 4'd3, 0, 2'b01));
    expect_out(1, 1, "R3 no pulse for 01");
    expect_out(0, {16'b0, mk(0, exp_scale(SWORD, 3), 4'd3, 0, 2'b11)}, "R3 state kept, select taken");
    tick();
    drive_cfg(mk(0, 0, 4'd0, 0, 2'b10));
    expect_out(1, 1, "R3 no pulse for 10");
    expect_out(0, {16'b0, mk(0, exp_scale(SWORD, 0), 4'd0, 0, 2'b11)}, "R3 state kept");
    tick();
    drive_cfg(mk(0, 0, 4'd0, 0, 2'b11));
    expect_out(1, 1, "R2 no pulse 11->11");
    tick();

    drive_cfg(mk(0, 0, 4'd0, 0, 2'b00));
    expect_out(1, 0, "R2 pulse on 11->00");
    expect_out(3, 0, "R4 local reset starts");
    expect_out(4, 1, "R4 reload request");
    expect_out(5, 0, "R4 data cleared");
    expect_out(0, 32'h0, "R4 scale cleared");
    expect_out(6, 1, "R5 mem_io back");
    tick();
    drive_ee(2'd0, 32'h55555555);
    expect_out(3, 0, "R4 reset cycle 2");
    expect_out(4, 0, "R4 reload single");
    tick();
    expect_out(3, 0, "R4 reset cycle 3");
    tick();
    expect_out(3, 0, "R4 reset cycle 4");
    tick();
    expect_out(3, 1, "R4 reset ends");
    expect_out(5, 0, "R4 write in window ignored");
    tick();
    drive_ee(2'd0, DWORD);
    expect_out(5, {24'b0, DWORD[7:0]}, "R10 reload data");
    tick();
    drive_ee(2'd1, SWORD); tick();

    drive_cfg(mk(0, 0, 4'd0, 1, 2'b00));
    expect_out(2, 1, "R7 enabled but no status");
    tick();
    wake_set_in = 1'b1;
    expect_out(2, 1, "R6 status not yet set");
    tick();
    expect_out(2, 0, "R7 wake asserted");
    expect_out(0, {16'b0, mk(1, 2'b11, 4'd0, 1, 2'b00)}, "R6 status set");
    tick();
    drive_cfg(mk(1, 0, 4'd0, 1, 2'b00));
    expect_out(2, 1, "R8 cleared releases wake");
    expect_out(0, {16'b0, mk(0, 2'b11, 4'd0, 1, 2'b00)}, "R8 w1c");
    tick();
    tick(); tick();
    expect_out(0, {16'b0, mk(0, 2'b11, 4'd0, 1, 2'b00)}, "R6 held level sets once");
    tick();

    wake_set_in = 1'b0; tick();
    wake_set_in = 1'b1; tick();
    tick();
    drive_cfg(mk(0, 0, 4'd0, 1, 2'b00));
    expect_out(0, {16'b0, mk(1, 2'b11, 4'd0, 1, 2'b00)}, "R8 write 0 keeps status");
    tick();
    drive_ee(2'd2, 32'h0);
    expect_out(2, 1, "R9 eeprom disable");
    expect_out(0, {16'b0, mk(1, 2'b11, 4'd0, 0, 2'b00)}, "R9 enable 0 via eeprom");
    tick();
    drive_cfg(mk(0, 0, 4'd0, 1, 2'b00));
    expect_out(2, 0, "R7 re-enabled by host");
    tick();
    drive_cfg(mk(0, 0, 4'd0, 0, 2'b00));
    expect_out(2, 1, "R9 host disable");
    tick();

    drive_cfg(mk(1, 0, 4'd0, 0, 2'b00));
    tick();
    wake_set_in = 1'b0; tick(); tick();
    wake_set_in = 1'b1; tick();
    drive_cfg(mk(1, 0, 4'd0, 1, 2'b00));
    expect_out(0, {16'b0, mk(1, 2'b11, 4'd0, 1, 2'b00)}, "R8 set beats clear");
    expect_out(2, 0, "R7 wake on set");
    tick();
    tick();

    done = 1;
    finish_run();
  end

endmodule